// File: doc/BRIEF.md
# GEMM Tile Command Sequencer

The sequencer turns one matrix-multiply job into a stream of stage commands for the engines that do the work downstream. A start pulse captures the M, K and N extents, the three tile sizes, the element size in bytes and three base addresses. The block then walks the tile grid with M outermost, N in the middle and K innermost. For each tile it issues a fixed run of commands on a valid/ready stream. Each command carries an opcode, an address, a byte count, the running tile number and a last-K flag.

An element-wise mode walks an M×N grid instead. It uses one source base (the A base input) and one destination base (the C base input). Each tile issues read, fetch, math, store and write. Edge tiles are never clipped, so every tile uses the full tile sizes. After the final command of the final tile is accepted, a single-cycle done pulse reports that the job is complete.

Top module: `gemm_tile_seq`

## Requirements
- R1: After reset, cmd_valid_o and done_o are both low and stay low until a job is started.
- R2: Opcode values are read=0, fetch=1, mac=2, math=3, store=4, write=5. In GEMM mode (ew_mode_i=0) each tile issues read A, read B, fetch, mac, store, and then a write only on the last K tile.
- R3: The tile loop runs M outermost, then N, then K. A dimension yields max(1, ceil(dim/tile)) tiles, so a dimension of zero still gives one tile.
- R4: The GEMM read A address is A+(m·tm·K+k·tk)·bpe. The read B address is B+(k·tk·N+n·tn)·bpe. The write address is C+(m·tm·N+n·tn)·bpe. Here m, k and n are tile indices.
- R5: Byte counts are tm·tk·bpe for read A, tk·tn·bpe for read B, and their sum for fetch. Store and write carry tm·tn·bpe. Fetch and store have address 0. The mac command has byte count 0 and address {tm, tk, tn} in bits 23:16, 15:8 and 7:0.
- R6: In element-wise mode (ew_mode_i=1) each tile issues read, fetch, math, store, write. Read uses A+off and write uses C+off, where off=(m·tm·N+n·tn)·bpe. Every command except math carries tm·tn·bpe bytes. Math has address 0 and byte count tm·tn.
- R7: tile_id is 0 on the first tile and rises by one per tile. It is the same on every command of a tile. cmd_last_k_o is high on every command of the last K tile, and always high in element-wise mode.
- R8: While cmd_valid_o is high and cmd_ready_i is low, every command field holds its value.
- R9: done_o is high for exactly one cycle, in the cycle right after the final command is accepted. cmd_valid_o is low in that cycle.
- R10: A start pulse while a job is running is ignored. The running job's commands are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a job and captures the job inputs when idle |
| ew_mode_i | input | 1 | 0 selects GEMM mode, 1 selects element-wise mode |
| dim_m_i | input | DIM_W | M extent |
| dim_k_i | input | DIM_W | K extent |
| dim_n_i | input | DIM_W | N extent |
| tile_m_i | input | TILE_W | Tile size along M, at least 1 |
| tile_k_i | input | TILE_W | Tile size along K, at least 1 |
| tile_n_i | input | TILE_W | Tile size along N, at least 1 |
| bpe_i | input | BPE_W | Bytes per element |
| a_base_i | input | ADDR_W | A base, or source base in element-wise mode |
| b_base_i | input | ADDR_W | B base |
| c_base_i | input | ADDR_W | C base, or destination base in element-wise mode |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted by the consumer |
| cmd_op_o | output | 3 | Command opcode |
| cmd_addr_o | output | ADDR_W | Command address |
| cmd_nbytes_o | output | NB_W | Command byte or element count |
| cmd_tile_id_o | output | TID_W | Running tile number |
| cmd_last_k_o | output | 1 | Tile is the last along K |
| done_o | output | 1 | One-cycle pulse when the job completes |

## Verification
The bench uses three GEMM shapes, each checked command by command against a reference loop.
- The first shape has extents that are exact multiples of the tiles. It separates correct M-N-K ordering and stride arithmetic from an off-by-one.
- The second has ragged extents. It catches a faulty ceiling and last-tile test, because an extra or missing tile shifts every later command.
- The third has all extents zero. It shows the one-tile minimum.

An element-wise job checks the shorter sequence and the shared offset. Stalls of varying length on every command test field hold. A start pulse injected mid-job, with altered inputs, tells a block that ignores it from one that restarts.

// File: rtl/gts_pkg.sv
package gts_pkg;
  typedef enum logic [2:0] {
    OP_RD    = 3'd0,
    OP_FETCH = 3'd1,
    OP_MAC   = 3'd2,
    OP_MATH  = 3'd3,
    OP_STORE = 3'd4,
    OP_WR    = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } st_e;
endpackage

// File: rtl/gts_stride.sv
// Registered products of the captured job parameters; settle one cycle after capture.
module gts_stride #(
  parameter int DIM_W  = 16,
  parameter int TILE_W = 8,
  parameter int BPE_W  = 4,
  parameter int ADDR_W = 32,
  parameter int NB_W   = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIM_W-1:0]  dim_k_i,
  input  logic [DIM_W-1:0]  dim_n_i,
  input  logic [TILE_W-1:0] tile_m_i,
  input  logic [TILE_W-1:0] tile_k_i,
  input  logic [TILE_W-1:0] tile_n_i,
  input  logic [BPE_W-1:0]  bpe_i,
  output logic [ADDR_W-1:0] sa_m_o,
  output logic [ADDR_W-1:0] sa_k_o,
  output logic [ADDR_W-1:0] sb_k_o,
  output logic [ADDR_W-1:0] s_n_o,
  output logic [ADDR_W-1:0] sc_m_o,
  output logic [NB_W-1:0]   a_bytes_o,
  output logic [NB_W-1:0]   b_bytes_o,
  output logic [NB_W-1:0]   o_bytes_o,
  output logic [NB_W-1:0]   o_elems_o
);
  localparam int PW = 2*TILE_W + DIM_W + BPE_W;

  logic [PW-1:0] tm, tk, tn, dk, dn, bp;
  assign tm = PW'(tile_m_i);
  assign tk = PW'(tile_k_i);
  assign tn = PW'(tile_n_i);
  assign dk = PW'(dim_k_i);
  assign dn = PW'(dim_n_i);
  assign bp = PW'(bpe_i);

  logic [PW-1:0] p_sa_m, p_sa_k, p_sb_k, p_s_n, p_sc_m, p_ab, p_bb, p_ob, p_oe;
  assign p_sa_m = tm * dk * bp;
  assign p_sa_k = tk * bp;
  assign p_sb_k = tk * dn * bp;
  assign p_s_n  = tn * bp;
  assign p_sc_m = tm * dn * bp;
  assign p_ab   = tm * tk * bp;
  assign p_bb   = tk * tn * bp;
  assign p_ob   = tm * tn * bp;
  assign p_oe   = tm * tn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_m_o <= '0; sa_k_o <= '0; sb_k_o <= '0; s_n_o <= '0; sc_m_o <= '0;
      a_bytes_o <= '0; b_bytes_o <= '0; o_bytes_o <= '0; o_elems_o <= '0;
    end else begin
      sa_m_o    <= ADDR_W'(p_sa_m);
      sa_k_o    <= ADDR_W'(p_sa_k);
      sb_k_o    <= ADDR_W'(p_sb_k);
      s_n_o     <= ADDR_W'(p_s_n);
      sc_m_o    <= ADDR_W'(p_sc_m);
      a_bytes_o <= NB_W'(p_ab);
      b_bytes_o <= NB_W'(p_bb);
      o_bytes_o <= NB_W'(p_ob);
      o_elems_o <= NB_W'(p_oe);
    end
  end
endmodule

// File: rtl/gts_walk.sv
// Tile-space walker: positions in elements, offsets accumulated in bytes.
module gts_walk #(
  parameter int DIM_W  = 16,
  parameter int TILE_W = 8,
  parameter int ADDR_W = 32,
  parameter int TID_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              adv_i,
  input  logic              ew_i,
  input  logic [DIM_W-1:0]  dim_m_i,
  input  logic [DIM_W-1:0]  dim_k_i,
  input  logic [DIM_W-1:0]  dim_n_i,
  input  logic [TILE_W-1:0] tile_m_i,
  input  logic [TILE_W-1:0] tile_k_i,
  input  logic [TILE_W-1:0] tile_n_i,
  input  logic [ADDR_W-1:0] sa_m_i,
  input  logic [ADDR_W-1:0] sa_k_i,
  input  logic [ADDR_W-1:0] sb_k_i,
  input  logic [ADDR_W-1:0] s_n_i,
  input  logic [ADDR_W-1:0] sc_m_i,
  output logic              m_last_o,
  output logic              n_last_o,
  output logic              k_last_o,
  output logic [ADDR_W-1:0] a_off_o,
  output logic [ADDR_W-1:0] b_off_o,
  output logic [ADDR_W-1:0] c_off_o,
  output logic [TID_W-1:0]  tile_id_o
);
  localparam int EW = DIM_W + 1;

  logic [DIM_W-1:0]  m_pos, n_pos, k_pos;
  logic [ADDR_W-1:0] a_row, a_k, b_k, n_off, c_row;

  // last tile once the next step would reach or pass the extent (zero extent -> one tile)
  assign m_last_o = (EW'(m_pos) + EW'(tile_m_i)) >= EW'(dim_m_i);
  assign n_last_o = (EW'(n_pos) + EW'(tile_n_i)) >= EW'(dim_n_i);
  assign k_last_o = ew_i | ((EW'(k_pos) + EW'(tile_k_i)) >= EW'(dim_k_i));

  assign a_off_o = a_row + a_k;
  assign b_off_o = b_k + n_off;
  assign c_off_o = c_row + n_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pos <= '0; n_pos <= '0; k_pos <= '0;
      a_row <= '0; a_k <= '0; b_k <= '0; n_off <= '0; c_row <= '0;
      tile_id_o <= '0;
    end else if (clear_i) begin
      m_pos <= '0; n_pos <= '0; k_pos <= '0;
      a_row <= '0; a_k <= '0; b_k <= '0; n_off <= '0; c_row <= '0;
      tile_id_o <= '0;
    end else if (adv_i) begin
      tile_id_o <= tile_id_o + 1'b1;
      if (k_last_o) begin
        k_pos <= '0; a_k <= '0; b_k <= '0;
        if (n_last_o) begin
          n_pos <= '0; n_off <= '0;
          m_pos <= m_pos + DIM_W'(tile_m_i);
          a_row <= a_row + sa_m_i;
          c_row <= c_row + sc_m_i;
        end else begin
          n_pos <= n_pos + DIM_W'(tile_n_i);
          n_off <= n_off + s_n_i;
        end
      end else begin
        k_pos <= k_pos + DIM_W'(tile_k_i);
        a_k   <= a_k + sa_k_i;
        b_k   <= b_k + sb_k_i;
      end
    end
  end
endmodule

// File: rtl/gts_emit.sv
// Per-tile stage counter; the last step depends on mode and on the K position.
module gts_emit (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       fire_i,
  input  logic       ew_i,
  input  logic       k_last_i,
  output logic [2:0] step_o,
  output logic       tile_end_o
);
  assign tile_end_o = (!ew_i && k_last_i) ? (step_o == 3'd5) : (step_o == 3'd4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       step_o <= '0;
    else if (clear_i)  step_o <= '0;
    else if (fire_i)   step_o <= tile_end_o ? 3'd0 : step_o + 3'd1;
  end
endmodule

// File: rtl/gemm_tile_seq.sv
module gemm_tile_seq
  import gts_pkg::*;
#(
  parameter int DIM_W  = 16,
  parameter int TILE_W = 8,
  parameter int BPE_W  = 4,
  parameter int ADDR_W = 32,
  parameter int NB_W   = 24,
  parameter int TID_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ew_mode_i,
  input  logic [DIM_W-1:0]  dim_m_i,
  input  logic [DIM_W-1:0]  dim_k_i,
  input  logic [DIM_W-1:0]  dim_n_i,
  input  logic [TILE_W-1:0] tile_m_i,
  input  logic [TILE_W-1:0] tile_k_i,
  input  logic [TILE_W-1:0] tile_n_i,
  input  logic [BPE_W-1:0]  bpe_i,
  input  logic [ADDR_W-1:0] a_base_i,
  input  logic [ADDR_W-1:0] b_base_i,
  input  logic [ADDR_W-1:0] c_base_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_op_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [NB_W-1:0]   cmd_nbytes_o,
  output logic [TID_W-1:0]  cmd_tile_id_o,
  output logic              cmd_last_k_o,
  output logic              done_o
);
  st_e               st_q;
  logic              ew_q;
  logic [DIM_W-1:0]  dm_q, dk_q, dn_q;
  logic [TILE_W-1:0] tm_q, tk_q, tn_q;
  logic [BPE_W-1:0]  bpe_q;
  logic [ADDR_W-1:0] a_base_q, b_base_q, c_base_q;

  logic              take, fire, tile_end, m_last, n_last, k_last;
  logic [2:0]        step;
  logic [ADDR_W-1:0] sa_m, sa_k, sb_k, s_n, sc_m, a_off, b_off, c_off;
  logic [NB_W-1:0]   a_bytes, b_bytes, o_bytes, o_elems;
  op_e               op;

  assign take        = start_i && (st_q == ST_IDLE);
  assign cmd_valid_o = (st_q == ST_RUN);
  assign fire        = cmd_valid_o && cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; done_o <= 1'b0; ew_q <= 1'b0;
      dm_q <= '0; dk_q <= '0; dn_q <= '0;
      tm_q <= '0; tk_q <= '0; tn_q <= '0; bpe_q <= '0;
      a_base_q <= '0; b_base_q <= '0; c_base_q <= '0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q <= ST_LOAD; ew_q <= ew_mode_i;
          dm_q <= dim_m_i; dk_q <= dim_k_i; dn_q <= dim_n_i;
          tm_q <= tile_m_i; tk_q <= tile_k_i; tn_q <= tile_n_i; bpe_q <= bpe_i;
          a_base_q <= a_base_i; b_base_q <= b_base_i; c_base_q <= c_base_i;
        end
        ST_LOAD: st_q <= ST_RUN;
        default: if (fire && tile_end && m_last && n_last && k_last) begin
          st_q   <= ST_IDLE;
          done_o <= 1'b1;
        end
      endcase
    end
  end

  gts_stride #(.DIM_W(DIM_W), .TILE_W(TILE_W), .BPE_W(BPE_W), .ADDR_W(ADDR_W), .NB_W(NB_W)) u_stride (
    .clk_i, .rst_ni,
    .dim_k_i(dk_q), .dim_n_i(dn_q),
    .tile_m_i(tm_q), .tile_k_i(tk_q), .tile_n_i(tn_q), .bpe_i(bpe_q),
    .sa_m_o(sa_m), .sa_k_o(sa_k), .sb_k_o(sb_k), .s_n_o(s_n), .sc_m_o(sc_m),
    .a_bytes_o(a_bytes), .b_bytes_o(b_bytes), .o_bytes_o(o_bytes), .o_elems_o(o_elems)
  );

  gts_walk #(.DIM_W(DIM_W), .TILE_W(TILE_W), .ADDR_W(ADDR_W), .TID_W(TID_W)) u_walk (
    .clk_i, .rst_ni,
    .clear_i(take), .adv_i(fire && tile_end), .ew_i(ew_q),
    .dim_m_i(dm_q), .dim_k_i(dk_q), .dim_n_i(dn_q),
    .tile_m_i(tm_q), .tile_k_i(tk_q), .tile_n_i(tn_q),
    .sa_m_i(sa_m), .sa_k_i(sa_k), .sb_k_i(sb_k), .s_n_i(s_n), .sc_m_i(sc_m),
    .m_last_o(m_last), .n_last_o(n_last), .k_last_o(k_last),
    .a_off_o(a_off), .b_off_o(b_off), .c_off_o(c_off),
    .tile_id_o(cmd_tile_id_o)
  );

  gts_emit u_emit (
    .clk_i, .rst_ni,
    .clear_i(take), .fire_i(fire), .ew_i(ew_q), .k_last_i(k_last),
    .step_o(step), .tile_end_o(tile_end)
  );

  always_comb begin
    op           = OP_WR;
    cmd_addr_o   = c_base_q + c_off;
    cmd_nbytes_o = o_bytes;
    if (!ew_q) begin
      case (step)
        3'd0: begin op = OP_RD;    cmd_addr_o = a_base_q + a_off; cmd_nbytes_o = a_bytes; end
        3'd1: begin op = OP_RD;    cmd_addr_o = b_base_q + b_off; cmd_nbytes_o = b_bytes; end
        3'd2: begin op = OP_FETCH; cmd_addr_o = '0; cmd_nbytes_o = a_bytes + b_bytes; end
        3'd3: begin op = OP_MAC;   cmd_addr_o = ADDR_W'({tm_q, tk_q, tn_q}); cmd_nbytes_o = '0; end
        3'd4: begin op = OP_STORE; cmd_addr_o = '0; end
        default: ;
      endcase
    end else begin
      case (step)
        3'd0: begin op = OP_RD;    cmd_addr_o = a_base_q + c_off; end
        3'd1: begin op = OP_FETCH; cmd_addr_o = '0; end
        3'd2: begin op = OP_MATH;  cmd_addr_o = '0; cmd_nbytes_o = o_elems; end
        3'd3: begin op = OP_STORE; cmd_addr_o = '0; end
        default: ;
      endcase
    end
  end

  assign cmd_op_o     = op;
  assign cmd_last_k_o = k_last;
endmodule

// File: rtl/gts_checker.sv
module gts_checker #(
  parameter int ADDR_W = 32,
  parameter int NB_W   = 24,
  parameter int TID_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [2:0]        cmd_op_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic [NB_W-1:0]   cmd_nbytes_o,
  input logic [TID_W-1:0]  cmd_tile_id_o,
  input logic              cmd_last_k_o,
  input logic              done_o
);
  a_r8_hold_under_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_addr_o)
      && $stable(cmd_nbytes_o) && $stable(cmd_tile_id_o) && $stable(cmd_last_k_o));

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cmd_valid_o);

  a_r2_op_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_op_o <= 3'd5);

  a_r2_write_on_last_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 3'd5 |-> cmd_last_k_o);

  a_r5_mac_no_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == 3'd2 |-> cmd_nbytes_o == '0);
endmodule

bind gemm_tile_seq gts_checker #(.ADDR_W(ADDR_W), .NB_W(NB_W), .TID_W(TID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_op_o(cmd_op_o), .cmd_addr_o(cmd_addr_o), .cmd_nbytes_o(cmd_nbytes_o),
  .cmd_tile_id_o(cmd_tile_id_o), .cmd_last_k_o(cmd_last_k_o), .done_o(done_o)
);

// File: tb/gemm_tile_seq_tb.sv
module gemm_tile_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, ew = 1'b0, ready = 1'b0;
  logic [15:0] dm = '0, dk = '0, dn = '0;
  logic [7:0]  tm = 8'd1, tk = 8'd1, tn = 8'd1;
  logic [3:0]  bpe = 4'd1;
  logic [31:0] ab = '0, bb = '0, cb = '0;
  logic        valid, last_k, done;
  logic [2:0]  op;
  logic [31:0] addr;
  logic [23:0] nb;
  logic [15:0] tid;

  int total = 0, bad = 0, stall_ph = 0;

  always #4 clk = ~clk;

  gemm_tile_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ew_mode_i(ew),
    .dim_m_i(dm), .dim_k_i(dk), .dim_n_i(dn),
    .tile_m_i(tm), .tile_k_i(tk), .tile_n_i(tn), .bpe_i(bpe),
    .a_base_i(ab), .b_base_i(bb), .c_base_i(cb),
    .cmd_valid_o(valid), .cmd_ready_i(ready), .cmd_op_o(op), .cmd_addr_o(addr),
    .cmd_nbytes_o(nb), .cmd_tile_id_o(tid), .cmd_last_k_o(last_k), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // wait for a command, stall a varying number of cycles, compare, accept
  task automatic get_cmd(input int e_op, input longint e_addr, input longint e_nb,
                         input int e_tid, input bit e_lk, input string req);
    int w = 0;
    int stall;
    logic [2:0] s_op; logic [31:0] s_addr; logic [23:0] s_nb; logic [15:0] s_tid; logic s_lk;
    ready = 1'b0;
    while (!valid && w < 50) begin @(negedge clk); w++; end
    chk(valid, req, "valid", valid, 1);
    s_op = op; s_addr = addr; s_nb = nb; s_tid = tid; s_lk = last_k;
    stall = stall_ph % 3; stall_ph++;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(op == s_op && addr == s_addr && nb == s_nb && tid == s_tid && last_k == s_lk,
          "R8", "hold", {29'b0, op}, {29'b0, s_op});
    end
    chk(op == 3'(e_op), req, "op", op, e_op);
    chk(addr == 32'(e_addr), req, "addr", addr, 32'(e_addr));
    chk(nb == 24'(e_nb), req, "nbytes", nb, 24'(e_nb));
    chk(tid == 16'(e_tid), "R7", "tile_id", tid, e_tid);
    chk(last_k == e_lk, "R7", "last_k", last_k, e_lk);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
  endtask

  task automatic launch(input bit mode, input int m, input int k, input int n,
                        input int t_m, input int t_k, input int t_n, input int b);
    ew = mode; dm = 16'(m); dk = 16'(k); dn = 16'(n);
    tm = 8'(t_m); tk = 8'(t_k); tn = 8'(t_n); bpe = 4'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic int ntiles(input int d, input int t);
    int r = (d + t - 1) / t;
    return (r < 1) ? 1 : r;
  endfunction

  task automatic check_end(input string req);
    chk(done == 1'b1, "R9", {req, " done"}, done, 1);
    chk(valid == 1'b0, "R9", {req, " idle"}, valid, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9", {req, " done drop"}, done, 0);
  endtask

  // reference GEMM walk: M, then N, then K
  task automatic expect_gemm(input int m, input int k, input int n, input int t_m,
                             input int t_k, input int t_n, input int b, input string req);
    int tid_e = 0;
    longint ab_l = ab, bb_l = bb, cb_l = cb;
    for (int mi = 0; mi < ntiles(m, t_m); mi++)
      for (int ni = 0; ni < ntiles(n, t_n); ni++)
        for (int ki = 0; ki < ntiles(k, t_k); ki++) begin
          bit lk = (ki == ntiles(k, t_k) - 1);
          longint a_nb = t_m * t_k * b, b_nb = t_k * t_n * b, o_nb = t_m * t_n * b;
          get_cmd(0, ab_l + longint'(mi*t_m*k + ki*t_k) * b, a_nb, tid_e, lk, "R4");
          get_cmd(0, bb_l + longint'(ki*t_k*n + ni*t_n) * b, b_nb, tid_e, lk, "R4");
          get_cmd(1, 0, a_nb + b_nb, tid_e, lk, "R5");
          get_cmd(2, (t_m << 16) | (t_k << 8) | t_n, 0, tid_e, lk, "R5");
          get_cmd(4, 0, o_nb, tid_e, lk, "R2");
          if (lk) get_cmd(5, cb_l + longint'(mi*t_m*n + ni*t_n) * b, o_nb, tid_e, lk, "R2");
          tid_e++;
        end
    check_end(req);
  endtask

  task automatic t_reset;
    chk(valid == 1'b0, "R1", "valid after reset", valid, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
  endtask

  task automatic t_gemm_even;
    ab = 32'h1000_0000; bb = 32'h2000_0000; cb = 32'h3000_0000;
    launch(0, 8, 8, 8, 4, 4, 4, 2);
    expect_gemm(8, 8, 8, 4, 4, 4, 2, "R3");
  endtask

  task automatic t_gemm_ragged;
    ab = 32'h0000_4000; bb = 32'h0001_0000; cb = 32'h0002_0000;
    launch(0, 5, 3, 9, 4, 2, 4, 2);
    expect_gemm(5, 3, 9, 4, 2, 4, 2, "R3");
  endtask

  task automatic t_gemm_zero;
    ab = 32'h100; bb = 32'h200; cb = 32'h300;
    launch(0, 0, 0, 0, 3, 5, 7, 1);
    expect_gemm(0, 0, 0, 3, 5, 7, 1, "R3");
  endtask

  task automatic t_elementwise;
    int tid_e = 0;
    ab = 32'h5000_0000; cb = 32'h6000_0000;
    launch(1, 6, 9, 10, 4, 1, 4, 4);
    for (int mi = 0; mi < ntiles(6, 4); mi++)
      for (int ni = 0; ni < ntiles(10, 4); ni++) begin
        longint off = longint'(mi*4*10 + ni*4) * 4;
        get_cmd(0, longint'(ab) + off, 64, tid_e, 1'b1, "R6");
        get_cmd(1, 0, 64, tid_e, 1'b1, "R6");
        get_cmd(3, 0, 16, tid_e, 1'b1, "R6");
        get_cmd(4, 0, 64, tid_e, 1'b1, "R6");
        get_cmd(5, longint'(cb) + off, 64, tid_e, 1'b1, "R6");
        tid_e++;
      end
    check_end("R6");
  endtask

  task automatic t_start_busy;
    ab = 32'h0A00_0000; bb = 32'h0B00_0000; cb = 32'h0C00_0000;
    launch(0, 4, 4, 2, 2, 2, 2, 1);
    while (!valid) @(negedge clk);
    ab = 32'hDEAD_0000; dm = 16'd40; ew = 1'b1; tm = 8'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ab = 32'h0A00_0000;
    expect_gemm(4, 4, 2, 2, 2, 2, 1, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_gemm_even();
    t_gemm_ragged();
    t_gemm_zero();
    t_elementwise();
    t_start_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule